// File: doc/BRIEF.md
# Queued SPI Master

This block is a full-duplex SPI master that runs serial transfers from a four-entry transmit queue, so the host does not take part once a job is queued. The host writes a queue entry in one clock cycle. An entry is a 32-bit data word and a 2-bit slave index. The sequencer pops each entry when the controller is idle and drives the matching active-low chip select. It then shifts the word out MSB first while it captures MISO into a receive register. At the end of the transfer it returns the received word together with the slave index of the entry.

The serial clock half-period lasts `div+1` system cycles. `cpol` and `cpha` select one of the four SPI modes. `cpol`, `cpha` and `div` are all sampled when an entry is popped, and each entry carries its own slave index. Back-to-back entries can therefore address different slaves.

The state machine has five states:
- **IDLE**: the serial clock follows `cpol`. When the queue is not empty, the transition to **SETUP** pops an entry.
- **SETUP**: chip select is low and the serial clock has not yet toggled. One half-period tick moves the machine to **SHIFT**.
- **SHIFT**: 64 ticks, one serial clock edge per tick. The tick on the last edge moves the machine to **HOLD**.
- **HOLD**: chip select stays low for one more half-period. The tick that releases chip select pulses the result and moves the machine to **GAP**.
- **GAP**: all chip selects stay high for one half-period. Its tick returns the machine to **IDLE**.

Top module: `spi_cmd_master`

## Requirements
- R1: While reset is held, and after its release, `cs_n` is 4'b1111, `busy`, `full`, `overflow` and `rx_valid` are 0, and `empty` is 1.
- R2: The queue holds 4 entries. A write with `wr_en` high and `full` low stores `wr_data`/`wr_slave` in one cycle. `empty` is 1 exactly when no entry is stored, and `full` is 1 exactly when 4 entries are stored.
- R3: A write while `full` is 1 is discarded, so the entry is never transmitted. It also sets `overflow`, which stays at 1 until reset.
- R4: One transfer is 32 serial clock periods. Each period is 2×(`div`+1) system cycles, with `div`, `cpol` and `cpha` sampled at the pop. While no transfer runs, `sclk` rests at `cpol`.
- R5: Slave index i drives `cs_n[i]` low and keeps every other `cs_n` bit high. At most one bit is ever low.
- R6: Chip select falls in the pop cycle, 2×(`div`+1) cycles before the first `sclk` edge. It rises `div`+1 cycles after the last edge. All chip selects then stay high for at least `div`+2 cycles before the next entry's chip select falls.
- R7: MOSI sends the word MSB first. With `cpha`=0, bit 31 is on `mosi` from the fall of chip select and the line changes on trailing edges. With `cpha`=1, the line changes on leading edges, starting with bit 31 on the first.
- R8: MISO is sampled on leading edges when `cpha`=0 and on trailing edges when `cpha`=1. The first bit sampled ends up in `rx_data[31]`.
- R9: `rx_valid` is a one-cycle pulse in the cycle that chip select rises. In that cycle, `rx_data` carries the received word and `rx_slave` carries the entry's slave index.
- R10: `busy` is 1 from the pop cycle until chip select rises. Queued entries run one after another with no host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Word to transmit |
| wr_slave | input | 2 | Slave index for the word |
| full | output | 1 | Queue holds 4 entries |
| empty | output | 1 | Queue holds no entry |
| overflow | output | 1 | Sticky: a write was dropped |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| div | input | 8 | Half-period length minus one, in system cycles |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| busy | output | 1 | Transfer in progress |
| rx_valid | output | 1 | One-cycle result strobe |
| rx_data | output | 32 | Received word |
| rx_slave | output | 2 | Slave index of the received word |

## Verification
A stray half-period counter or edge counter shows up on `sclk` within one half-period, as a toggle that is too early or a missing toggle. It also moves the rise of chip select and the `rx_valid` pulse, which the bench compares against the pop cycle on every clock. A wrong sequencer state appears at once on `cs_n` or `busy`. A bad queue pointer or count appears on `full`/`empty` in the next cycle, and as a wrong word or slave index at the next `rx_valid`. A shift register that is off by one bit shows up on `mosi` at the next drive edge and in `rx_data` when the transfer ends.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } spi_state_t;

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DW    = 32,
    parameter int IW    = 2,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [IW-1:0] head_idx,
    output logic          full,
    output logic          empty,
    output logic          overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem_d [DEPTH];
    logic [IW-1:0] mem_i [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          accept, take;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign accept    = push && !full;
    assign take      = pop && !empty;
    assign head_data = mem_d[rd_ptr];
    assign head_idx  = mem_i[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_d[wr_ptr] <= push_data;
            mem_i[wr_ptr] <= push_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            if (accept && !take)      count <= count + 1'b1;
            else if (take && !accept) count <= count - 1'b1;
            if (push && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          preload,
    input  logic          drive,
    input  logic          sample,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] tx_sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sreg <= '0;
            rx_word <= '0;
            mosi    <= 1'b0;
        end else begin
            if (load) begin
                rx_word <= '0;
                if (preload) begin
                    mosi    <= load_data[DW-1];
                    tx_sreg <= {load_data[DW-2:0], 1'b0};
                end else begin
                    tx_sreg <= load_data;
                end
            end else begin
                if (drive) begin
                    mosi    <= tx_sreg[DW-1];
                    tx_sreg <= {tx_sreg[DW-2:0], 1'b0};
                end
                if (sample) rx_word <= {rx_word[DW-2:0], miso};
            end
        end
    end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
    parameter int DW    = 32,
    parameter int IW    = 2,
    parameter int DEPTH = 4,
    parameter int DIVW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic [IW-1:0]     wr_slave,
    output logic              full,
    output logic              empty,
    output logic              overflow,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIVW-1:0]   div,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [(1<<IW)-1:0] cs_n,
    output logic              busy,
    output logic              rx_valid,
    output logic [DW-1:0]     rx_data,
    output logic [IW-1:0]     rx_slave
);
    import spi_cmd_pkg::*;

    localparam int NCS       = 1 << IW;
    localparam int EW        = $clog2(2 * DW);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

    spi_state_t      state, nxt;
    logic [DW-1:0]   head_data, rx_word;
    logic [IW-1:0]   head_idx, slave_q;
    logic [NCS-1:0]  sel_dec;
    logic [DIVW-1:0] div_q;
    logic [EW-1:0]   edge_cnt;
    logic            pol_q, pha_q;
    logic            pop, tick, run, lead, drive, sample;

    for (genvar g = 0; g < NCS; g++) begin : g_dec
        assign sel_dec[g] = (head_idx == IW'(g));
    end

    assign pop    = (state == ST_IDLE) && !empty;
    assign run    = (state != ST_IDLE);
    assign lead   = !edge_cnt[0];
    assign drive  = (state == ST_SHIFT) && tick &&
                    (pha_q ? lead : (!lead && edge_cnt != LAST_EDGE));
    assign sample = (state == ST_SHIFT) && tick && (pha_q ? !lead : lead);

    spi_cmd_fifo #(.DW(DW), .IW(IW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .push_idx  (wr_slave),
        .pop       (pop),
        .head_data (head_data),
        .head_idx  (head_idx),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow)
    );

    spi_cmd_tick #(.DIVW(DIVW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    spi_cmd_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pop),
        .load_data (head_data),
        .preload   (!cpha),
        .drive     (drive),
        .sample    (sample),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!empty) nxt = ST_SETUP;
            ST_SETUP: if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && edge_cnt == LAST_EDGE) nxt = ST_HOLD;
            ST_HOLD:  if (tick) nxt = ST_GAP;
            ST_GAP:   if (tick) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // registered outputs and per-transfer configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n     <= '1;
            busy     <= 1'b0;
            sclk     <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_slave <= '0;
            slave_q  <= '0;
            div_q    <= '0;
            pol_q    <= 1'b0;
            pha_q    <= 1'b0;
            edge_cnt <= '0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk <= cpol;
                    if (pop) begin
                        cs_n     <= ~sel_dec;
                        busy     <= 1'b1;
                        slave_q  <= head_idx;
                        div_q    <= div;
                        pol_q    <= cpol;
                        pha_q    <= cpha;
                        edge_cnt <= '0;
                    end
                end
                ST_SETUP: begin
                    sclk <= pol_q;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk     <= ~sclk;
                        edge_cnt <= edge_cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        cs_n     <= '1;
                        busy     <= 1'b0;
                        rx_valid <= 1'b1;
                        rx_data  <= rx_word;
                        rx_slave <= slave_q;
                    end
                end
                ST_GAP: begin
                    cs_n <= '1;
                end
                default: begin
                    cs_n <= '1;
                    busy <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           full,
    input logic           empty,
    input logic           overflow,
    input logic [NCS-1:0] cs_n,
    input logic           busy,
    input logic           rx_valid
);
    // R5: never more than one chip select low
    a_r5_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R10: a low chip select is always covered by busy
    a_r10_busy_covers_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> busy);

    // R9: result strobe lasts one cycle
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: result strobe coincides with chip-select release
    a_r9_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (cs_n == '1 && $past(cs_n) != '1 && !busy));

    // R3: overflow is sticky
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R2: full and empty exclusive
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R6: no direct hand-over between slaves without a deselect gap
    a_r6_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) != '1 && cs_n != '1) |-> (cs_n == $past(cs_n)));
endmodule

bind spi_cmd_master spi_cmd_checker #(.NCS(1 << IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .empty    (empty),
    .overflow (overflow),
    .cs_n     (cs_n),
    .busy     (busy),
    .rx_valid (rx_valid)
);

// File: tb/tb_spi_cmd_master.sv
`timescale 1ns/1ps
module tb_spi_cmd_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_slave = '0;
    logic        full, empty, overflow;
    logic        cpol = 1'b0, cpha = 1'b0;
    logic [7:0]  div = 8'd1;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;
    logic        busy, rx_valid;
    logic [31:0] rx_data;
    logic [1:0]  rx_slave;

    always #2.5 clk = ~clk;

    spi_cmd_master dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_slave(wr_slave), .full(full), .empty(empty), .overflow(overflow),
        .cpol(cpol), .cpha(cpha), .div(div), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .busy(busy), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_slave(rx_slave)
    );

    int tests = 0, fails = 0, rx_seen = 0;
    bit done = 0, model_on = 0;

    // reference model state
    logic [31:0] qd[$];
    logic [1:0]  qs[$];
    int    cyc = 0, t0 = 0, h = 1, next_ok = 0;
    bit    active = 0, m_pol = 0, m_pha = 0, m_ov = 0, last_cpol = 0;
    logic [31:0] m_data, m_pat;
    logic [1:0]  m_slave;

    function automatic logic [31:0] pattern(input logic [31:0] d);
        return {d[15:0], d[31:16]} ^ 32'hC3A5_0F96;
    endfunction

    function automatic int edges_done(input int d, input int hp);
        int e;
        if (d < 2 * hp) return 0;
        e = d / hp - 1;
        return (e > 64) ? 64 : e;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // model update at each active edge
    always @(posedge clk) begin
        if (rst_n && model_on) begin
            cyc++;
            if (active && (cyc - t0) >= 67 * h) active = 0;
            if (!active && cyc >= next_ok && qd.size() > 0) begin
                active  = 1;
                t0      = cyc;
                m_data  = qd.pop_front();
                m_slave = qs.pop_front();
                m_pat   = pattern(m_data);
                h       = int'(div) + 1;
                m_pol   = cpol;
                m_pha   = cpha;
                next_ok = t0 + 67 * h + 1;
            end
            if (wr_en) begin
                if (qd.size() < 4) begin
                    qd.push_back(wr_data);
                    qs.push_back(wr_slave);
                end else m_ov = 1;
            end
            last_cpol = cpol;
        end
    end

    // slave model: present the next MISO bit after each sampling edge
    always @(negedge clk) begin
        if (active) begin
            int n, s;
            n = edges_done(cyc - t0, h);
            s = m_pha ? n / 2 : (n + 1) / 2;
            miso <= (s < 32) ? m_pat[31 - s] : 1'b0;
        end else miso <= 1'b0;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && model_on && cyc > 0) begin
            int d, n, bitn;
            bit sel, exp_sclk, exp_valid;
            logic [3:0] exp_cs;
            d   = cyc - t0;
            sel = active && d < 66 * h;
            n   = active ? edges_done(d, h) : 0;
            exp_sclk  = active ? (m_pol ^ n[0]) : last_cpol;
            exp_valid = active && d == 66 * h;
            exp_cs    = sel ? ~(4'b0001 << m_slave) : 4'b1111;
            check("R4", "sclk", {31'b0, sclk}, {31'b0, exp_sclk});
            check("R5/R6", "cs_n", {28'b0, cs_n}, {28'b0, exp_cs});
            check("R10", "busy", {31'b0, busy}, {31'b0, sel});
            check("R9", "rx_valid", {31'b0, rx_valid}, {31'b0, exp_valid});
            check("R2", "empty", {31'b0, empty}, {31'b0, qd.size() == 0});
            check("R2", "full", {31'b0, full}, {31'b0, qd.size() == 4});
            check("R3", "overflow", {31'b0, overflow}, {31'b0, m_ov});
            if (sel) begin
                if (!m_pha) begin
                    bitn = 31 - ((n / 2 > 31) ? 31 : n / 2);
                    check("R7", "mosi cpha0", {31'b0, mosi}, {31'b0, m_data[bitn]});
                end else if (n >= 1) begin
                    bitn = 32 - (n + 1) / 2;
                    check("R7", "mosi cpha1", {31'b0, mosi}, {31'b0, m_data[bitn]});
                end
            end
            if (exp_valid) begin
                rx_seen++;
                check("R8", "rx_data", rx_data, m_pat);
                check("R9", "rx_slave", {30'b0, rx_slave}, {30'b0, m_slave});
            end
        end
    end

    task automatic put(input logic [31:0] d, input logic [1:0] s);
        wr_en = 1'b1; wr_data = d; wr_slave = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (active || qd.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values under reset
        check("R1", "cs_n in reset", {28'b0, cs_n}, 32'hF);
        check("R1", "busy in reset", {31'b0, busy}, 32'h0);
        check("R1", "empty in reset", {31'b0, empty}, 32'h1);
        check("R1", "full in reset", {31'b0, full}, 32'h0);
        check("R1", "overflow in reset", {31'b0, overflow}, 32'h0);
        check("R1", "rx_valid in reset", {31'b0, rx_valid}, 32'h0);
        rst_n = 1'b1;
        model_on = 1;
        repeat (3) @(negedge clk);

        // mode 0, div 1: fill the queue behind a running transfer
        put(32'hA5A5_0001, 2'd2);
        repeat (10) @(negedge clk);
        put(32'h1234_5678, 2'd0);
        put(32'h8000_0001, 2'd1);
        put(32'hFFFF_0000, 2'd3);
        put(32'h0F0F_F0F0, 2'd2);
        check("R2", "full after four queued", {31'b0, full}, 32'h1);
        put(32'hDEAD_BEEF, 2'd1);
        check("R3", "overflow after dropped write", {31'b0, overflow}, 32'h1);
        drain();
        check("R3", "transfers after dropped write", rx_seen, 5);

        // mode 1, div 0: same slave twice then another
        cpol = 1'b0; cpha = 1'b1; div = 8'd0;
        repeat (3) @(negedge clk);
        put(32'hCAFE_F00D, 2'd3);
        put(32'h0000_0001, 2'd3);
        put(32'h7654_3210, 2'd0);
        drain();

        // mode 2, div 2
        cpol = 1'b1; cpha = 1'b0; div = 8'd2;
        repeat (3) @(negedge clk);
        put(32'h5555_AAAA, 2'd1);
        put(32'h8765_4321, 2'd2);
        drain();

        // mode 3, div 3
        cpol = 1'b1; cpha = 1'b1; div = 8'd3;
        repeat (3) @(negedge clk);
        put(32'hFFFF_FFFF, 2'd0);
        put(32'h0000_0000, 2'd3);
        drain();

        check("R10", "total transfers", rx_seen, 12);
        check("R3", "overflow still set", {31'b0, overflow}, 32'h1);
        done = 1;
        summary();
    end
endmodule